// File: doc/BRIEF.md
# Camera Pixel Byte Serializer

This block sits at the end of a camera pipeline. It turns one processed pixel into two bytes on an 8-bit video bus, one byte per clock. Upstream logic presents luma and chroma samples, RGB565 components or a 10-bit raw Bayer sample, together with a pixel strobe and a line-active flag. A format select picks how the two byte slots of each pixel are filled. The block drives a byte and a byte-valid qualifier, and the qualifier is high only for bytes that carry pixel content.

Each accepted pixel occupies two consecutive output slots. The strobe is therefore honoured at most every second clock: a strobe in the clock right after an accepted pixel is dropped. For 4:2:2 output, even pixels of a line carry Cb and odd pixels carry Cr. If a line closes on an unpaired pixel, the block adds a padding pixel so that the pair is complete. The format select is captured only between lines. The upstream source must keep line-active low for at least three clocks between lines.

Top module: `pix_byte_fmt`

## Requirements
- R1: While rst_ni is low and on the first clock after release, byte_vld_o is 0 and byte_o is 0.
- R2: A pixel is accepted on a clock edge where line_act_i and pix_vld_i are high and the previous edge did not accept one. Its first byte slot appears in the clock after that edge and its second slot in the clock after that. A strobe on the edge right after an acceptance is ignored.
- R3: Format 0 (interleaved): even pixel slots are cb_i then y_i; odd pixel slots are cr_i then y_i. Both slots are valid.
- R4: Format 1 (luma first): even pixel slots are y_i then cb_i; odd pixel slots are y_i then cr_i. Both slots are valid.
- R5: Format 2 (luma only): the first slot is y_i and valid; the second slot is not valid.
- R6: Format 3 (chroma only): the first slot is cb_i on even pixels and cr_i on odd pixels, and it is valid; the second slot is not valid.
- R7: Format 4: the first byte is {r[4:0], g[5:3]} and the second byte is {g[2:0], b[4:0]}.
- R8: Format 5: the first byte is {b[4:0], g[5:3]} and the second byte is {g[2:0], r[4:0]}.
- R9: Formats 6 and 7 (raw): the first byte is {6'b0, raw[9:8]} and the second byte is raw[7:0].
- R10: The even/odd pixel count restarts at every line, so the first pixel of each line is even.
- R11: If a line ends after an odd number of pixels, the block emits one padding pixel on the first edge with line_act_i low and no slot pending. The padding pixel is formatted as an odd pixel whose chroma is the last accepted cb_i and whose luma is the last accepted y_i. Both of its slots are valid in formats 0 and 1. Only its first slot is valid in format 3. Neither slot is valid in formats 2 and 4 to 7.
- R12: fmt_i is captured only on edges where line_act_i is low and no padding pixel is owed. A change of fmt_i during a line has no effect on that line.
- R13: byte_o is 0 whenever byte_vld_o is 0. A strobe while line_act_i is low produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_act_i | input | 1 | Line-active window |
| pix_vld_i | input | 1 | Pixel strobe |
| fmt_i | input | 3 | Output format select |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference chroma sample |
| cr_i | input | 8 | Red-difference chroma sample |
| r_i | input | 5 | RGB565 red |
| g_i | input | 6 | RGB565 green |
| b_i | input | 5 | RGB565 blue |
| raw_i | input | 10 | Raw Bayer sample |
| byte_o | output | 8 | Output byte |
| byte_vld_o | output | 1 | Output byte qualifier |

## Verification
The hardest case to reach is the padding pixel after an odd-length line. It has to be hit in every format, with the line closing both while a second slot is still pending and while the output is idle. The stimulus covers this by ending lines of odd length under three strobe patterns: every second clock, continuous, and random gaps. This puts the falling edge of the line at every possible slot position. A continuous strobe also drives the ignored second-slot case. A separate line changes fmt_i while it is active, to show that the captured format holds for the whole line.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    FMT_CYCY   = 3'd0,
    FMT_YCYC   = 3'd1,
    FMT_LUMA   = 3'd2,
    FMT_CHROMA = 3'd3,
    FMT_RGB_A  = 3'd4,
    FMT_RGB_B  = 3'd5,
    FMT_RAW    = 3'd6,
    FMT_RAW_X  = 3'd7
  } fmt_e;

  typedef struct packed {
    logic [BYTE_W-1:0] b0;
    logic [BYTE_W-1:0] b1;
    logic              v0;
    logic              v1;
  } slot_pair_t;
endpackage

// File: rtl/pix_pair_ctrl.sv
module pix_pair_ctrl
  import pix_fmt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_act_i,
  input  logic pix_vld_i,
  input  fmt_e fmt_i,
  output logic accept_o,
  output logic pad_o,
  output logic phase_o,
  output logic pend_o,
  output fmt_e mode_o
);
  logic pend_q, phase_q;
  fmt_e mode_q;

  assign accept_o = line_act_i & pix_vld_i & ~pend_q;
  // close an unpaired line once the bus is free
  assign pad_o    = ~line_act_i & phase_q & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      phase_q <= 1'b0;
      mode_q  <= FMT_CYCY;
    end else begin
      pend_q <= accept_o | pad_o;
      if (accept_o)   phase_q <= ~phase_q;
      else if (pad_o) phase_q <= 1'b0;
      if (!line_act_i && !phase_q) mode_q <= fmt_i;
    end
  end

  assign phase_o = phase_q;
  assign pend_o  = pend_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/pix_slot_encode.sv
module pix_slot_encode
  import pix_fmt_pkg::*;
#(
  parameter int R_W   = 5,
  parameter int G_W   = 6,
  parameter int B_W   = 5,
  parameter int RAW_W = 10
) (
  input  fmt_e              mode_i,
  input  logic              odd_i,
  input  logic              pad_i,
  input  logic [BYTE_W-1:0] y_i,
  input  logic [BYTE_W-1:0] cb_i,
  input  logic [BYTE_W-1:0] cr_i,
  input  logic [BYTE_W-1:0] last_y_i,
  input  logic [BYTE_W-1:0] last_cb_i,
  input  logic [R_W-1:0]    r_i,
  input  logic [G_W-1:0]    g_i,
  input  logic [B_W-1:0]    b_i,
  input  logic [RAW_W-1:0]  raw_i,
  output slot_pair_t        pair_o
);
  localparam int G_HI_W  = BYTE_W - R_W;
  localparam int G_LO_W  = G_W - G_HI_W;
  localparam int RAW_PAD = 2*BYTE_W - RAW_W;

  logic [BYTE_W-1:0] c, yy, raw_hi;

  generate
    if (RAW_PAD > 0) begin : g_raw_pad
      assign raw_hi = {{RAW_PAD{1'b0}}, raw_i[RAW_W-1:BYTE_W]};
    end else begin : g_raw_full
      assign raw_hi = raw_i[RAW_W-1:BYTE_W];
    end
  endgenerate

  always_comb begin
    c  = pad_i ? last_cb_i : (odd_i ? cr_i : cb_i);
    yy = pad_i ? last_y_i : y_i;
    pair_o = '0;
    unique case (mode_i)
      FMT_CYCY:   begin pair_o.b0 = c;  pair_o.b1 = yy; pair_o.v0 = 1'b1; pair_o.v1 = 1'b1; end
      FMT_YCYC:   begin pair_o.b0 = yy; pair_o.b1 = c;  pair_o.v0 = 1'b1; pair_o.v1 = 1'b1; end
      FMT_LUMA:   begin pair_o.b0 = yy; pair_o.v0 = 1'b1; end
      FMT_CHROMA: begin pair_o.b0 = c;  pair_o.v0 = 1'b1; end
      FMT_RGB_A: begin
        pair_o.b0 = {r_i, g_i[G_W-1 -: G_HI_W]};
        pair_o.b1 = {g_i[G_LO_W-1:0], b_i};
        pair_o.v0 = 1'b1; pair_o.v1 = 1'b1;
      end
      FMT_RGB_B: begin
        pair_o.b0 = {b_i, g_i[G_W-1 -: G_HI_W]};
        pair_o.b1 = {g_i[G_LO_W-1:0], r_i};
        pair_o.v0 = 1'b1; pair_o.v1 = 1'b1;
      end
      default: begin
        pair_o.b0 = raw_hi;
        pair_o.b1 = raw_i[BYTE_W-1:0];
        pair_o.v0 = 1'b1; pair_o.v1 = 1'b1;
      end
    endcase
    if (pad_i) begin
      if (mode_i != FMT_CYCY && mode_i != FMT_YCYC) pair_o.v1 = 1'b0;
      if (mode_i != FMT_CYCY && mode_i != FMT_YCYC && mode_i != FMT_CHROMA) pair_o.v0 = 1'b0;
    end
  end
endmodule

// File: rtl/pix_byte_out.sv
module pix_byte_out
  import pix_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              pend_i,
  input  slot_pair_t        pair_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);
  logic [BYTE_W-1:0] hold_b;
  logic              hold_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      vld_o  <= 1'b0;
      hold_b <= '0;
      hold_v <= 1'b0;
    end else if (load_i) begin
      vld_o  <= pair_i.v0;
      byte_o <= pair_i.v0 ? pair_i.b0 : '0;
      hold_v <= pair_i.v1;
      hold_b <= pair_i.v1 ? pair_i.b1 : '0;
    end else if (pend_i) begin
      vld_o  <= hold_v;
      byte_o <= hold_b;
    end else begin
      vld_o  <= 1'b0;
      byte_o <= '0;
    end
  end
endmodule

// File: rtl/pix_byte_fmt.sv
module pix_byte_fmt
  import pix_fmt_pkg::*;
#(
  parameter int R_W   = 5,
  parameter int G_W   = 6,
  parameter int B_W   = 5,
  parameter int RAW_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_act_i,
  input  logic              pix_vld_i,
  input  logic [2:0]        fmt_i,
  input  logic [BYTE_W-1:0] y_i,
  input  logic [BYTE_W-1:0] cb_i,
  input  logic [BYTE_W-1:0] cr_i,
  input  logic [R_W-1:0]    r_i,
  input  logic [G_W-1:0]    g_i,
  input  logic [B_W-1:0]    b_i,
  input  logic [RAW_W-1:0]  raw_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  logic accept, pad, phase_q, pend_q;
  fmt_e mode_q;
  logic [BYTE_W-1:0] last_y, last_cb;
  slot_pair_t pair;

  pix_pair_ctrl i_ctrl (
    .clk_i, .rst_ni, .line_act_i, .pix_vld_i,
    .fmt_i   (fmt_e'(fmt_i)),
    .accept_o(accept),
    .pad_o   (pad),
    .phase_o (phase_q),
    .pend_o  (pend_q),
    .mode_o  (mode_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_y  <= '0;
      last_cb <= '0;
    end else if (accept) begin
      last_y  <= y_i;
      last_cb <= cb_i;
    end
  end

  pix_slot_encode #(.R_W(R_W), .G_W(G_W), .B_W(B_W), .RAW_W(RAW_W)) i_enc (
    .mode_i   (mode_q),
    .odd_i    (phase_q),
    .pad_i    (pad),
    .y_i, .cb_i, .cr_i,
    .last_y_i (last_y),
    .last_cb_i(last_cb),
    .r_i, .g_i, .b_i, .raw_i,
    .pair_o   (pair)
  );

  pix_byte_out i_out (
    .clk_i, .rst_ni,
    .load_i(accept | pad),
    .pend_i(pend_q),
    .pair_i(pair),
    .byte_o,
    .vld_o (byte_vld_o)
  );
endmodule

// File: rtl/pix_byte_fmt_chk.sv
module pix_byte_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_act_i,
  input logic       byte_vld_o,
  input logic [7:0] byte_o,
  input logic [2:0] mode_q,
  input logic       phase_q,
  input logic       pend_q
);
  assert_idle_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> byte_o == 8'd0);

  assert_mode_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_act_i |=> $stable(mode_q));

  assert_quiet_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_act_i && !phase_q && !pend_q) |=> !byte_vld_o);

  assert_phase_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_act_i && !pend_q) |=> !phase_q);

  assert_raw_high_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[2:1] == 2'b11 && byte_vld_o && pend_q) |-> byte_o[7:2] == 6'd0);
endmodule

bind pix_byte_fmt pix_byte_fmt_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .line_act_i(line_act_i),
  .byte_vld_o(byte_vld_o),
  .byte_o    (byte_o),
  .mode_q    (mode_q),
  .phase_q   (phase_q),
  .pend_q    (pend_q)
);

// File: tb/test_pix_byte_fmt.sv
module test_pix_byte_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_act = 1'b0, pix_vld = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [7:0] y = '0, cb = '0, cr = '0;
  logic [4:0] r = '0, b = '0;
  logic [5:0] g = '0;
  logic [9:0] raw = '0;
  logic [7:0] byte_q;
  logic byte_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_byte_fmt i_pix_byte_fmt (
    .clk_i(clk), .rst_ni(rst_n), .line_act_i(line_act), .pix_vld_i(pix_vld),
    .fmt_i(fmt), .y_i(y), .cb_i(cb), .cr_i(cr), .r_i(r), .g_i(g), .b_i(b),
    .raw_i(raw), .byte_o(byte_q), .byte_vld_o(byte_v)
  );

  typedef struct {logic v; logic [7:0] d; string tag;} exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0, n_acc = 0, cycles = 0;
  logic m_phase = 1'b0, first_pix = 1'b0;
  logic [2:0] m_mode = 3'd0;
  logic [7:0] m_last_y = '0, m_last_cb = '0;
  bit done = 0;

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R3"; 3'd1: return "R4"; 3'd2: return "R5"; 3'd3: return "R6";
      3'd4: return "R7"; 3'd5: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic push2(input logic v0, input logic [7:0] d0, input logic v1,
                       input logic [7:0] d1, input string t);
    exp_t e;
    e.v = v0; e.d = v0 ? d0 : 8'd0; e.tag = t; q.push_back(e);
    e.v = v1; e.d = v1 ? d1 : 8'd0; e.tag = t; q.push_back(e);
  endtask

  // expected slots for one pixel, built straight from the requirements
  task automatic expect_pix(input logic [2:0] m, input logic odd, input logic [7:0] yy,
                            input logic [7:0] c, input string t);
    case (m)
      3'd0: push2(1, c, 1, yy, t);
      3'd1: push2(1, yy, 1, c, t);
      3'd2: push2(1, yy, 0, 0, t);
      3'd3: push2(1, c, 0, 0, t);
      3'd4: push2(1, {r, g[5:3]}, 1, {g[2:0], b}, t);
      3'd5: push2(1, {b, g[5:3]}, 1, {g[2:0], r}, t);
      default: push2(1, {6'd0, raw[9:8]}, 1, raw[7:0], t);
    endcase
    if (odd) begin end
  endtask

  task automatic compare(input string idle_tag);
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else begin e.v = 0; e.d = 0; e.tag = idle_tag; end
    compared++;
    if (byte_v !== e.v || byte_q !== e.d) begin
      mismatched++;
      $display("FAIL %s: actual vld=%0b byte=%02h expected vld=%0b byte=%02h",
               e.tag, byte_v, byte_q, e.v, e.d);
    end
  endtask

  task automatic tick(input logic la, input logic pv, input logic [2:0] f);
    logic [31:0] rnd;
    logic old_ph;
    @(negedge clk);
    compare("R13");
    rnd = $urandom; y = rnd[7:0]; cb = rnd[15:8]; cr = rnd[23:16];
    r = rnd[28:24]; rnd = $urandom; g = rnd[5:0]; b = rnd[10:6]; raw = rnd[25:16];
    line_act = la; pix_vld = pv; fmt = f;
    old_ph = m_phase;
    if (la && pv && q.size() == 0) begin
      string t;
      t = first_pix ? "R10" : (f != m_mode ? "R12" : mode_tag(m_mode));
      expect_pix(m_mode, m_phase, y, m_phase ? cr : cb, t);
      m_last_y = y; m_last_cb = cb; m_phase = ~m_phase; first_pix = 0; n_acc++;
    end else if (la && pv && q.size() == 1) begin
      q[0].tag = "R2";
    end else if (!la && m_phase && q.size() == 0) begin
      case (m_mode)
        3'd0: push2(1, m_last_cb, 1, m_last_y, "R11");
        3'd1: push2(1, m_last_y, 1, m_last_cb, "R11");
        3'd3: push2(1, m_last_cb, 0, 0, "R11");
        default: push2(0, 0, 0, 0, "R11");
      endcase
      m_phase = 0;
    end
    if (!la && !old_ph) m_mode = f;
  endtask

  task automatic blank(input int k, input logic [2:0] f, input logic pv);
    for (int i = 0; i < k; i++) tick(0, pv, f);
  endtask

  // style 0: every second clock, 1: continuous strobe, 2: random gaps
  task automatic run_line(input int n, input int style, input logic [2:0] f);
    int start = n_acc;
    int k = 0;
    logic [31:0] rnd;
    first_pix = 1;
    while (n_acc - start < n) begin
      rnd = $urandom;
      tick(1, style == 1 ? 1'b1 : (style == 0 ? (k % 2 == 0) : (rnd % 3 == 0)), f);
      k++;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); compare("R1");
    end
    rst_n = 1'b1;
    @(negedge clk); compare("R1");
    for (int m = 0; m < 8; m++) begin
      blank(4, 3'(m), 1'b1);
      run_line(6, 0, 3'(m));
      blank(4, 3'(m), 1'b0);
      run_line(5, 2, 3'(m));
      blank(4, 3'(m), 1'b1);
      run_line(3, 1, 3'(m));
      blank(3, 3'(m), 1'b0);
      run_line(1, 0, 3'(m));
    end
    blank(4, 3'd0, 1'b0);
    run_line(7, 0, 3'd5);  // R12: format moves mid-line
    blank(4, 3'd1, 1'b0);
    run_line(4, 1, 3'd2);  // R12 again in another format
    blank(6, 3'd1, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule